// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Protection-Identifier Write Filter

This block is a small, fully associative address translation buffer whose contents are managed entirely by software. Each slot maps one virtual page, held as an inclusive begin..end address range, to a physical page number. A slot also carries an access identifier, a dirty attribute and a trap attribute. Slots are filled in two steps. An address step claims a slot and records the mapping but leaves the slot invalid. A protection step then writes the identifier and attributes and makes the slot valid. Commands can also purge one page or the whole buffer.

A combinational lookup port translates a virtual address for a load, a store or an instruction fetch. It returns the physical address, read/write/execute permissions, the two attributes and an exception code. Four protection-identifier registers and a protection-enable status bit form a write filter. When protection is enabled and a valid slot's identifier matches a register whose write-disable bit is set, write permission is withdrawn. A store to that page raises a protection exception. Any write to a protection-identifier register, and any change of the enable bit, pulses a flush-notify output so that translations cached downstream can be dropped.

Top module: `swtlb_pid`

## Requirements
- R1: A lookup whose address lies inside the begin..end range of an allocated, valid slot hits. It returns `lk_pa` = {physical page number, address bits [11:0]}, `lk_perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute), `lk_attr` = {trap, dirty} and `lk_exc` = 0 (none). When several slots cover the address, the lowest-indexed one is used.
- R2: If no allocated slot covers the address, or the covering slot is invalid, the lookup misses with `lk_perm` = 0, `lk_pa` = 0 and `lk_attr` = 0. `lk_exc` is 1 (instruction miss) when `lk_type` = 2 (fetch), and 2 (data miss) for `lk_type` 0 (load), 1 (store) or 3. After reset every lookup misses, including address 0.
- R3: Opcode 0 (insert-address) records a begin of `cmd_va` with bits [11:0] cleared, an end of begin + 4095, and a physical page number from `cmd_data[24:5]`. The slot is left invalid, so lookups to that page still miss.
- R4: When allocated slots already cover `cmd_va`, insert-address makes all of them invalid and rewrites the lowest-indexed one with the new mapping.
- R5: When no slot covers `cmd_va`, insert-address writes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such insert. With 8 slots, the ninth distinct page inserted after reset replaces the first.
- R6: Opcode 1 (insert-protection) on the lowest-indexed covering slot sets the access identifier from `cmd_data[15:1]`, dirty from `cmd_data[28]` and trap from `cmd_data[29]`, and marks the slot valid. This holds whether or not the slot was already valid.
- R7: Insert-protection to an address that no allocated slot covers changes nothing.
- R8: Opcode 2 (purge-page) deallocates every slot covering `cmd_va` and leaves all other slots intact.
- R9: Opcode 3 (purge-all) deallocates every slot. A later insert-protection cannot revive any of them.
- R10: Protection-identifier register k is written from `pid_wdata` when `pid_we` is high and `pid_sel` = k. Its bits [15:1] hold an identifier and bit 0 is a write-disable flag. One cycle after `prot_en` is sampled high, a hit whose slot identifier is nonzero and equals bits [15:1] of any register with bit 0 set returns `lk_perm` = 3'b101.
- R11: A store (`lk_type` = 1) that meets the R10 condition returns `lk_exc` = 3 (protection), `lk_perm` = 3'b101, `lk_pa` = 0 and `lk_attr` = 0.
- R12: No write filtering occurs when `prot_en` is low, when the slot identifier is 0, or when the matching register's bit 0 is clear.
- R13: `flush_notify` is high for the cycle after a clock edge at which `pid_we` was high or `prot_en` differed from its value at the previous edge. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high, one command per cycle) |
| cmd_op | input | 2 | 0 insert-address, 1 insert-protection, 2 purge-page, 3 purge-all |
| cmd_va | input | 32 | Virtual address the command applies to |
| cmd_data | input | 32 | Operand: page number [24:5], identifier [15:1], dirty [28], trap [29] |
| pid_we | input | 1 | Protection-identifier register write strobe |
| pid_sel | input | 2 | Register selected for write |
| pid_wdata | input | 16 | Identifier [15:1] and write-disable flag [0] |
| prot_en | input | 1 | Protection-enable status bit |
| lk_va | input | 32 | Lookup virtual address |
| lk_type | input | 2 | 0 load, 1 store, 2 fetch |
| lk_pa | output | 32 | Translated physical address (0 on exception) |
| lk_perm | output | 3 | Permissions {execute, write, read} |
| lk_attr | output | 2 | {trap, dirty} of the hit slot |
| lk_exc | output | 2 | 0 none, 1 instruction miss, 2 data miss, 3 protection |
| flush_notify | output | 1 | One-cycle pulse after protection state changes |

## Verification
Some properties are checked by assertions on every cycle. An exception code always comes with zero permissions and a zero address on a miss. An instruction-miss code appears only for fetches. A protection code appears only for stores and always with read and execute kept. A purge-all leaves every lookup missing on the next cycle. A register write or an enable change is followed by a flush pulse. Other behaviour needs directed scenarios from the bench, because it depends on the history of slot contents: the two-step fill, slot reuse on re-insertion, round-robin eviction, purge scope, and the individual conditions that disable the identifier filter.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

    typedef enum logic [1:0] {
        OP_INS_ADDR   = 2'd0,
        OP_INS_PROT   = 2'd1,
        OP_PURGE_PAGE = 2'd2,
        OP_PURGE_ALL  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_IMISS = 2'd1,
        EXC_DMISS = 2'd2,
        EXC_PROT  = 2'd3
    } exc_e;

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_NO_W = 3'b101;
    localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/swtlb_cover.sv
module swtlb_cover #(
    parameter int N    = 8,
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0]         addr,
    input  logic [N-1:0]            alloc,
    input  logic [N-1:0][VA_W-1:0]  lo,
    input  logic [N-1:0][VA_W-1:0]  hi,
    output logic [N-1:0]            hit
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        assign hit[g] = alloc[g] && (addr >= lo[g]) && (addr <= hi[g]);
    end
endmodule

// File: rtl/swtlb_first.sv
module swtlb_first #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/swtlb_pid_filter.sv
module swtlb_pid_filter #(
    parameter int AID_W = 15,
    parameter int NPID  = 4
) (
    input  logic                   en,
    input  logic [AID_W-1:0]       aid,
    input  logic [NPID-1:0][AID_W:0] pid,
    output logic                   block
);
    logic [NPID-1:0] match;
    for (genvar g = 0; g < NPID; g++) begin : g_pid
        assign match[g] = (pid[g] == {aid, 1'b1});
    end
    assign block = en && (|aid) && (|match);
endmodule

// File: rtl/swtlb_pid.sv
module swtlb_pid
    import swtlb_pkg::*;
#(
    parameter int NUM_ENT   = 8,
    parameter int VA_W      = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    parameter int PPN_LSB   = 5,
    parameter int AID_W     = 15,
    parameter int AID_LSB   = 1,
    parameter int D_BIT     = 28,
    parameter int T_BIT     = 29,
    parameter int NUM_PID   = 4,
    localparam int PA_W     = PPN_W + PAGE_BITS,
    localparam int IDX_W    = $clog2(NUM_ENT),
    localparam int PSEL_W   = $clog2(NUM_PID),
    localparam int PID_W    = AID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              pid_we,
    input  logic [PSEL_W-1:0] pid_sel,
    input  logic [PID_W-1:0]  pid_wdata,
    input  logic              prot_en,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [1:0]        lk_type,
    output logic [PA_W-1:0]   lk_pa,
    output logic [2:0]        lk_perm,
    output logic [1:0]        lk_attr,
    output logic [1:0]        lk_exc,
    output logic              flush_notify
);
    localparam logic [VA_W-1:0] PAGE_LAST = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

    typedef struct packed {
        logic              alloc;
        logic              valid;
        logic [VA_W-1:0]   vb;
        logic [VA_W-1:0]   ve;
        logic [PPN_W-1:0]  ppn;
        logic [AID_W-1:0]  aid;
        logic              dirty;
        logic              trap;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_ENT-1:0]              ent;
        logic [IDX_W-1:0]                rr;
        logic [NUM_PID-1:0][PID_W-1:0]   pid;
        logic                            pen;
        logic                            flush;
    } st_t;

    st_t s_q, s_d;

    logic [NUM_ENT-1:0]            ent_alloc;
    logic [NUM_ENT-1:0][VA_W-1:0]  ent_vb;
    logic [NUM_ENT-1:0][VA_W-1:0]  ent_ve;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            ent_alloc[i] = s_q.ent[i].alloc;
            ent_vb[i]    = s_q.ent[i].vb;
            ent_ve[i]    = s_q.ent[i].ve;
        end
    end

    // ---------------- lookup side ----------------
    logic [NUM_ENT-1:0] lk_hit;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    ent_t               lk_ent;
    logic               lk_block;

    swtlb_cover #(.N(NUM_ENT), .VA_W(VA_W)) u_lk_cover (
        .addr(lk_va), .alloc(ent_alloc), .lo(ent_vb), .hi(ent_ve), .hit(lk_hit)
    );
    swtlb_first #(.N(NUM_ENT), .IW(IDX_W)) u_lk_first (
        .vec(lk_hit), .any(lk_any), .idx(lk_idx)
    );

    assign lk_ent = s_q.ent[lk_idx];

    swtlb_pid_filter #(.AID_W(AID_W), .NPID(NUM_PID)) u_filter (
        .en(s_q.pen), .aid(lk_ent.aid), .pid(s_q.pid), .block(lk_block)
    );

    always_comb begin
        lk_pa   = '0;
        lk_perm = PERM_NONE;
        lk_attr = 2'b00;
        lk_exc  = EXC_NONE;
        if (!lk_any || !lk_ent.valid) begin
            lk_exc = (acc_e'(lk_type) == ACC_FETCH) ? EXC_IMISS : EXC_DMISS;
        end else if (lk_block && acc_e'(lk_type) == ACC_STORE) begin
            lk_perm = PERM_NO_W;
            lk_exc  = EXC_PROT;
        end else begin
            lk_perm = lk_block ? PERM_NO_W : PERM_ALL;
            lk_pa   = {lk_ent.ppn, lk_va[PAGE_BITS-1:0]};
            lk_attr = {lk_ent.trap, lk_ent.dirty};
        end
    end

    // ---------------- command side ----------------
    logic [NUM_ENT-1:0] cmd_hit;
    logic               cmd_any;
    logic [IDX_W-1:0]   cmd_idx;
    logic [IDX_W-1:0]   slot;
    logic [VA_W-1:0]    new_vb;
    logic               cmd_fire;

    swtlb_cover #(.N(NUM_ENT), .VA_W(VA_W)) u_cmd_cover (
        .addr(cmd_va), .alloc(ent_alloc), .lo(ent_vb), .hi(ent_ve), .hit(cmd_hit)
    );
    swtlb_first #(.N(NUM_ENT), .IW(IDX_W)) u_cmd_first (
        .vec(cmd_hit), .any(cmd_any), .idx(cmd_idx)
    );

    assign cmd_ready = 1'b1;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign new_vb    = {cmd_va[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    assign slot      = cmd_any ? cmd_idx : s_q.rr;

    logic unused_bits;
    assign unused_bits = ^{cmd_data, cmd_va[PAGE_BITS-1:0]};

    always_comb begin
        s_d       = s_q;
        s_d.pen   = prot_en;
        s_d.flush = (prot_en != s_q.pen);
        if (pid_we) begin
            s_d.pid[pid_sel] = pid_wdata;
            s_d.flush        = 1'b1;
        end
        if (cmd_fire) begin
            unique case (cmd_op_e'(cmd_op))
                OP_INS_ADDR: begin
                    for (int i = 0; i < NUM_ENT; i++) begin
                        if (cmd_hit[i]) s_d.ent[i].valid = 1'b0;
                    end
                    s_d.ent[slot].alloc = 1'b1;
                    s_d.ent[slot].valid = 1'b0;
                    s_d.ent[slot].vb    = new_vb;
                    s_d.ent[slot].ve    = new_vb + PAGE_LAST;
                    s_d.ent[slot].ppn   = cmd_data[PPN_LSB +: PPN_W];
                    s_d.ent[slot].aid   = '0;
                    s_d.ent[slot].dirty = 1'b0;
                    s_d.ent[slot].trap  = 1'b0;
                    if (!cmd_any) begin
                        s_d.rr = (s_q.rr == IDX_W'(NUM_ENT - 1)) ? '0 : s_q.rr + 1'b1;
                    end
                end
                OP_INS_PROT: begin
                    if (cmd_any) begin
                        s_d.ent[cmd_idx].aid   = cmd_data[AID_LSB +: AID_W];
                        s_d.ent[cmd_idx].dirty = cmd_data[D_BIT];
                        s_d.ent[cmd_idx].trap  = cmd_data[T_BIT];
                        s_d.ent[cmd_idx].valid = 1'b1;
                    end
                end
                OP_PURGE_PAGE: begin
                    for (int i = 0; i < NUM_ENT; i++) begin
                        if (cmd_hit[i]) begin
                            s_d.ent[i].alloc = 1'b0;
                            s_d.ent[i].valid = 1'b0;
                        end
                    end
                end
                OP_PURGE_ALL: begin
                    for (int i = 0; i < NUM_ENT; i++) begin
                        s_d.ent[i].alloc = 1'b0;
                        s_d.ent[i].valid = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flush_notify = s_q.flush;

endmodule

// File: rtl/swtlb_pid_chk.sv
module swtlb_pid_chk
    import swtlb_pkg::*;
#(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_op,
    input logic            pid_we,
    input logic            prot_en,
    input logic [1:0]      lk_type,
    input logic [PA_W-1:0] lk_pa,
    input logic [2:0]      lk_perm,
    input logic [1:0]      lk_exc,
    input logic            flush_notify
);
    p_miss_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_exc == EXC_IMISS || lk_exc == EXC_DMISS) |-> (lk_perm == PERM_NONE && lk_pa == '0));

    p_imiss_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_exc == EXC_IMISS) |-> (lk_type == ACC_FETCH));

    p_prot_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_exc == EXC_PROT) |-> (lk_type == ACC_STORE && lk_perm == PERM_NO_W && lk_pa == '0));

    p_purge_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_PURGE_ALL) |=> (lk_exc == EXC_IMISS || lk_exc == EXC_DMISS));

    p_flush_pid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pid_we |=> flush_notify);

    p_flush_pen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_en) |=> flush_notify);
endmodule

bind swtlb_pid swtlb_pid_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .pid_we(pid_we), .prot_en(prot_en), .lk_type(lk_type),
    .lk_pa(lk_pa), .lk_perm(lk_perm), .lk_exc(lk_exc), .flush_notify(flush_notify)
);

// File: tb/swtlb_pid_tb.sv
`timescale 1ns/1ps
module swtlb_pid_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_va = '0;
    logic [31:0] cmd_data = '0;
    logic        pid_we = 1'b0;
    logic [1:0]  pid_sel = '0;
    logic [15:0] pid_wdata = '0;
    logic        prot_en = 1'b0;
    logic [31:0] lk_va = '0;
    logic [1:0]  lk_type = '0;
    logic [31:0] lk_pa;
    logic [2:0]  lk_perm;
    logic [1:0]  lk_attr;
    logic [1:0]  lk_exc;
    logic        flush_notify;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    swtlb_pid u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_data(cmd_data), .pid_we(pid_we),
        .pid_sel(pid_sel), .pid_wdata(pid_wdata), .prot_en(prot_en), .lk_va(lk_va),
        .lk_type(lk_type), .lk_pa(lk_pa), .lk_perm(lk_perm), .lk_attr(lk_attr),
        .lk_exc(lk_exc), .flush_notify(flush_notify)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] va, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_data = data;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic ins_addr(input logic [31:0] va, input logic [19:0] ppn);
        cmd(2'd0, va, {7'd0, ppn, 5'd0});
    endtask

    task automatic ins_prot(input logic [31:0] va, input logic [14:0] aid, input bit d, input bit t);
        cmd(2'd1, va, {2'd0, t, d, 12'd0, aid, 1'b0});
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] ty, input logic [31:0] epa,
                        input logic [2:0] eperm, input logic [1:0] eexc, input string tag);
        lk_va = va; lk_type = ty;
        #1;
        chk(lk_pa == epa,     {tag, " pa"},   lk_pa,   epa);
        chk(lk_perm == eperm, {tag, " perm"}, lk_perm, eperm);
        chk(lk_exc == eexc,   {tag, " exc"},  lk_exc,  eexc);
    endtask

    task automatic write_pid(input logic [1:0] sel, input logic [15:0] val);
        pid_we = 1'b1; pid_sel = sel; pid_wdata = val;
        tick();
        pid_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(flush_notify == 1'b0, "reset flush", flush_notify, 0);
        look(32'h0, 2'd0, 32'h0, 3'b000, 2'd2, "R2 reset load page0");
        look(32'h1234, 2'd2, 32'h0, 3'b000, 2'd1, "R2 fetch miss");
        look(32'h1234, 2'd1, 32'h0, 3'b000, 2'd2, "R2 store miss");
    endtask

    task automatic t_two_step();
        ins_addr(32'h5ABC, 20'h12345);
        look(32'h5ABC, 2'd0, 32'h0, 3'b000, 2'd2, "R3 invalid after addr step");
        ins_prot(32'h5000, 15'h0, 1'b1, 1'b0);
        look(32'h5FFF, 2'd1, 32'h12345FFF, 3'b111, 2'd0, "R1 hit end of page");
        chk(lk_attr == 2'b01, "R6 attr dirty", lk_attr, 2'b01);
        look(32'h5000, 2'd2, 32'h12345000, 3'b111, 2'd0, "R3 begin aligned");
        look(32'h6000, 2'd0, 32'h0, 3'b000, 2'd2, "R3 end bound");
        look(32'h4FFF, 2'd0, 32'h0, 3'b000, 2'd2, "R3 below begin");
    endtask

    task automatic t_reinsert();
        ins_addr(32'h5010, 20'h0AAAA);
        look(32'h5010, 2'd0, 32'h0, 3'b000, 2'd2, "R4 reinsert invalidates");
        ins_prot(32'h5000, 15'h0, 1'b0, 1'b1);
        look(32'h5010, 2'd0, 32'h0AAAA010, 3'b111, 2'd0, "R4 new mapping");
        chk(lk_attr == 2'b10, "R6 attr trap", lk_attr, 2'b10);
        ins_prot(32'h5800, 15'h0, 1'b1, 1'b1);
        look(32'h5010, 2'd0, 32'h0AAAA010, 3'b111, 2'd0, "R6 prot on valid slot");
        chk(lk_attr == 2'b11, "R6 attr rewrite", lk_attr, 2'b11);
    endtask

    task automatic t_prot_ignored();
        ins_prot(32'h9000, 15'h3, 1'b1, 1'b1);
        look(32'h9000, 2'd0, 32'h0, 3'b000, 2'd2, "R7 uncovered prot ignored");
        look(32'h5010, 2'd1, 32'h0AAAA010, 3'b111, 2'd0, "R7 other slot untouched");
    endtask

    task automatic t_pid();
        ins_addr(32'h7000, 20'h00777);
        ins_prot(32'h7000, 15'h1234, 1'b0, 1'b0);
        write_pid(2'd0, 16'h2469);
        chk(flush_notify == 1'b1, "R13 flush after pid write", flush_notify, 1);
        tick();
        chk(flush_notify == 1'b0, "R13 flush one cycle", flush_notify, 0);
        look(32'h7004, 2'd1, 32'h00777004, 3'b111, 2'd0, "R12 enable low");
        prot_en = 1'b1;
        tick();
        chk(flush_notify == 1'b1, "R13 flush on enable rise", flush_notify, 1);
        look(32'h7004, 2'd1, 32'h0, 3'b101, 2'd3, "R11 store protected");
        look(32'h7004, 2'd0, 32'h00777004, 3'b101, 2'd0, "R10 load keeps read");
        look(32'h7004, 2'd2, 32'h00777004, 3'b101, 2'd0, "R10 fetch keeps exec");
        tick();
        chk(flush_notify == 1'b0, "R13 flush drops", flush_notify, 0);
        write_pid(2'd0, 16'h2468);
        look(32'h7004, 2'd1, 32'h00777004, 3'b111, 2'd0, "R12 disable bit clear");
        write_pid(2'd3, 16'h2469);
        look(32'h7004, 2'd0, 32'h00777004, 3'b101, 2'd0, "R10 match in last reg");
        write_pid(2'd1, 16'h0001);
        look(32'h5010, 2'd1, 32'h0AAAA010, 3'b111, 2'd0, "R12 public page");
        prot_en = 1'b0;
        tick();
        chk(flush_notify == 1'b1, "R13 flush on enable fall", flush_notify, 1);
        look(32'h7004, 2'd1, 32'h00777004, 3'b111, 2'd0, "R12 enable cleared");
    endtask

    task automatic t_purge();
        cmd(2'd2, 32'h7123, 32'h0);
        look(32'h7004, 2'd0, 32'h0, 3'b000, 2'd2, "R8 purged page");
        look(32'h5010, 2'd0, 32'h0AAAA010, 3'b111, 2'd0, "R8 other page kept");
        cmd(2'd3, 32'h0, 32'h0);
        look(32'h5010, 2'd0, 32'h0, 3'b000, 2'd2, "R9 purge all");
        ins_prot(32'h5000, 15'h0, 1'b0, 1'b0);
        look(32'h5010, 2'd0, 32'h0, 3'b000, 2'd2, "R9 no revive");
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 9; i++) begin
            ins_addr(32'h10000 + 32'(i) * 32'h1000, 20'h100 + 20'(i));
            ins_prot(32'h10000 + 32'(i) * 32'h1000, 15'h0, 1'b0, 1'b0);
        end
        look(32'h10008, 2'd0, 32'h0, 3'b000, 2'd2, "R5 first page evicted");
        look(32'h11008, 2'd0, 32'h00101008, 3'b111, 2'd0, "R5 second page kept");
        look(32'h18008, 2'd0, 32'h00108008, 3'b111, 2'd0, "R5 ninth page present");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset();
        t_two_step();
        t_reinsert();
        t_prot_ignored();
        t_pid();
        t_purge();
        t_round_robin();
        finish_run();
    end
endmodule